// File: doc/BRIEF.md
# Byte-Accessed Sample FIFO with Threshold

This block buffers 16-bit two's complement conversion results between an A/D sample source and an 8-bit host register port. Each sample enters as one word. The host drains it through a single data-port offset as two byte reads, low byte first. The word leaves the queue only when its high byte has been read.

The same data-port offset is writable. After a FIFO clear, the first four bytes written there program two thresholds. The near-empty threshold is a fill level in bytes. The near-full threshold is the number of bytes still free at which the near-full flag fires. A status byte shows the live level flags and three sticky events. Reading the status byte clears the events. An interrupt request follows the threshold event when it is enabled.

A clear command empties the queue and restarts both the byte-pair sequencing and the threshold-write sequencing. The programmed threshold values themselves are kept.

Top module: `byte_sample_fifo`

## Requirements
- R1: After `rst`, the FIFO is empty. A status read returns 8'h81 while `acq_running` is low. `fifo_irq` is 0, `near_empty` is 1, and `dport_rdata` is 8'h00.
- R2: Samples come out in arrival order. Each sample takes two data-port reads: the first returns bits 7:0 and the second returns bits 15:8.
- R3: The FIFO holds FIFO_BYTES/2 samples. A sample pushed while the FIFO is full is discarded and never read out, and it sets the data-lost event (status bit 5). Status bit 2 is 1 while the FIFO is full.
- R4: A data-port read while the FIFO is empty returns the previous byte again and moves no pointer. The next sample pushed is read out normally, low byte first.
- R5: After a clear, the first four data-port writes set these bytes, in this order: near-empty low, near-empty high, near-full low, near-full high. Any further writes are ignored until the next clear. Out of `rst`, the near-empty threshold is 0 and the near-full threshold is FIFO_BYTES/2.
- R6: Status bit 1 (near-full) is 1 while FIFO_BYTES − 2×(stored samples) ≤ the near-full threshold.
- R7: When near-full rises, the threshold event (status bit 3) is latched. `fifo_irq` equals that event ANDed with `fifo_irq_en`.
- R8: A status read returns the byte one cycle after `stat_rd` and clears bits 5, 4 and 3. An event that arrives in the same cycle as the read is kept. Bit 7 is the inverse of `acq_running` and bit 6 equals `acq_running`. Bit 0 is 1 when the FIFO is empty.
- R9: `fifo_clear` empties the FIFO, even in the middle of a byte pair. The next sample pushed reads out low byte first.
- R10: `near_empty` is 1 while 2×(stored samples) ≤ the near-empty threshold.
- R11: A `scan_end` pulse latches the end-of-scan event (status bit 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Push one sample |
| smp_data | input | 16 | Sample word, two's complement |
| acq_running | input | 1 | Acquisition engine is active |
| scan_end | input | 1 | End-of-scan pulse |
| dport_rd | input | 1 | Data-port read strobe |
| dport_wr | input | 1 | Data-port write strobe |
| dport_wdata | input | 8 | Data-port write byte |
| dport_rdata | output | 8 | Byte returned by the last data-port read |
| stat_rd | input | 1 | Status read strobe |
| stat_rdata | output | 8 | Status byte captured by the last status read |
| fifo_clear | input | 1 | Clear command pulse |
| fifo_irq_en | input | 1 | Interrupt enable for the threshold event |
| fifo_irq | output | 1 | Interrupt request |
| near_empty | output | 1 | Fill level at or below the near-empty threshold |

## Verification
Read data and status bytes are registered. They are valid one cycle after their strobe, so the bench drives each strobe on a falling edge and samples the result at the next falling edge. The level flags follow the sample count without delay and can be seen at the first status read after a push. The threshold event and `fifo_irq` come one cycle after near-full rises, so the bench lets two idle cycles pass after each push before it looks at them. A status read and an event in the same cycle are checked over two reads: the first read returns the old byte and the second shows the event.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int BYTE_W = 8;
    localparam int SMP_W  = 16;
    localparam int THR_W  = 16;
    localparam int LVL_W  = THR_W + 1;

    typedef logic [SMP_W-1:0]  sample_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [THR_W-1:0]  thr_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } phase_e;

    // Field order is the status byte layout, msb first.
    typedef struct packed {
        logic idle;
        logic running;
        logic lost;
        logic eos;
        logic thr;
        logic full;
        logic nfull;
        logic empty;
    } stat_t;

    function automatic byte_t pick_byte(input sample_t w, input phase_e ph);
        return (ph == PH_HI) ? w[15:8] : w[7:0];
    endfunction

    function automatic lvl_t words_to_bytes(input lvl_t words);
        return words << 1;
    endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  sample_t       wdata,
    input  logic          pop,
    output sample_t       head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    sample_t         mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   cnt_q;
    logic            push_ok, pop_ok;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push & ~full & ~clr;
    assign pop_ok  = pop & ~empty & ~clr;
    assign count   = cnt_q;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R3: never more samples than capacity
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R3: a push into a full queue with no pop leaves the level unchanged
    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !clr) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/sfifo_thresh.sv
module sfifo_thresh
    import sfifo_pkg::*;
#(
    parameter int FIFO_BYTES = 4096,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr,
    input  byte_t         wbyte,
    input  logic [CW-1:0] count,
    output logic          nfull,
    output logic          nempty,
    output logic          thr_set
);

    localparam thr_t NF_DEFAULT = THR_W'(FIFO_BYTES / 2);

    thr_t       thr_ne, thr_nf;
    logic [2:0] wr_idx;
    logic       nfull_q;
    lvl_t       level, free;

    assign level   = words_to_bytes(LVL_W'(count));
    assign free    = LVL_W'(FIFO_BYTES) - level;
    assign nfull   = (free <= {1'b0, thr_nf});
    assign nempty  = (level <= {1'b0, thr_ne});
    assign thr_set = nfull & ~nfull_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_ne  <= '0;
            thr_nf  <= NF_DEFAULT;
            wr_idx  <= '0;
            nfull_q <= 1'b0;
        end else begin
            nfull_q <= nfull;
            if (clr) begin
                wr_idx <= '0;
            end else if (wr && wr_idx < 3'd4) begin
                unique case (wr_idx[1:0])
                    2'd0: thr_ne[7:0]  <= wbyte;
                    2'd1: thr_ne[15:8] <= wbyte;
                    2'd2: thr_nf[7:0]  <= wbyte;
                    default: thr_nf[15:8] <= wbyte;
                endcase
                wr_idx <= wr_idx + 3'd1;
            end
        end
    end

    // R5: once four bytes are taken, more writes leave the near-full threshold alone
    p_extra_write_r5: assert property (@(posedge clk) disable iff (rst)
        (wr && wr_idx == 3'd4 && !clr) |=> $stable(thr_nf));

    // R7: the event pulse can only follow a cycle without near-full
    p_edge_only_r7: assert property (@(posedge clk) disable iff (rst)
        nfull |=> !thr_set);

endmodule

// File: rtl/sfifo_reader.sv
module sfifo_reader
    import sfifo_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    rd,
    input  sample_t head,
    input  logic    empty,
    output logic    pop,
    output byte_t   rdata
);

    phase_e phase;
    byte_t  rdata_q;

    assign pop   = rd & (phase == PH_HI) & ~clr;
    assign rdata = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_LO;
            rdata_q <= '0;
        end else if (clr) begin
            phase <= PH_LO;
        end else if (rd) begin
            if (phase == PH_HI) begin
                rdata_q <= pick_byte(head, PH_HI);
                phase   <= PH_LO;
            end else if (!empty) begin
                rdata_q <= pick_byte(head, PH_LO);
                phase   <= PH_HI;
            end
        end
    end

    // R4: a read of an empty queue repeats the previous byte
    p_empty_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (rd && empty && phase == PH_LO && !clr) |=> $stable(rdata_q));

    // R2: a half-read sample is still held by the store
    p_pair_held_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HI) |-> !empty);

endmodule

// File: rtl/sfifo_status.sv
module sfifo_status
    import sfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_stat,
    input  logic  set_lost,
    input  logic  set_eos,
    input  logic  set_thr,
    input  logic  running,
    input  logic  full,
    input  logic  nfull,
    input  logic  empty,
    input  logic  irq_en,
    output byte_t stat_rdata,
    output logic  irq
);

    logic  lost_q, eos_q, thr_q;
    stat_t snap;
    byte_t stat_q;

    always_comb begin
        snap.idle    = ~running;
        snap.running = running;
        snap.lost    = lost_q;
        snap.eos     = eos_q;
        snap.thr     = thr_q;
        snap.full    = full;
        snap.nfull   = nfull;
        snap.empty   = empty;
    end

    assign stat_rdata = stat_q;
    assign irq        = irq_en & thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lost_q <= 1'b0;
            eos_q  <= 1'b0;
            thr_q  <= 1'b0;
            stat_q <= '0;
        end else begin
            lost_q <= (lost_q & ~rd_stat) | set_lost;
            eos_q  <= (eos_q  & ~rd_stat) | set_eos;
            thr_q  <= (thr_q  & ~rd_stat) | set_thr;
            if (rd_stat) stat_q <= snap;
        end
    end

    // R8: a status read clears an event that is not set again
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !set_lost) |=> !lost_q);

    // R8: an event in the read cycle survives the read
    p_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && set_eos) |=> eos_q);

    // R7: the request drops after a status read with no new threshold event
    p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !set_thr) |=> !irq);

endmodule

// File: rtl/byte_sample_fifo.sv
module byte_sample_fifo
    import sfifo_pkg::*;
#(
    parameter int FIFO_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_valid,
    input  logic [15:0] smp_data,
    input  logic        acq_running,
    input  logic        scan_end,
    input  logic        dport_rd,
    input  logic        dport_wr,
    input  logic [7:0]  dport_wdata,
    output logic [7:0]  dport_rdata,
    input  logic        stat_rd,
    output logic [7:0]  stat_rdata,
    input  logic        fifo_clear,
    input  logic        fifo_irq_en,
    output logic        fifo_irq,
    output logic        near_empty
);

    localparam int DEPTH = FIFO_BYTES / 2;
    localparam int CW    = $clog2(DEPTH) + 1;

    sample_t       head;
    logic [CW-1:0] count;
    logic          full, empty, pop, nfull, thr_set, set_lost;

    assign set_lost = smp_valid & full & ~fifo_clear;

    sfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clear),
        .push  (smp_valid),
        .wdata (smp_data),
        .pop   (pop),
        .head  (head),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    sfifo_thresh #(.FIFO_BYTES(FIFO_BYTES), .CW(CW)) u_thresh (
        .clk     (clk),
        .rst     (rst),
        .clr     (fifo_clear),
        .wr      (dport_wr),
        .wbyte   (dport_wdata),
        .count   (count),
        .nfull   (nfull),
        .nempty  (near_empty),
        .thr_set (thr_set)
    );

    sfifo_reader u_reader (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clear),
        .rd    (dport_rd),
        .head  (head),
        .empty (empty),
        .pop   (pop),
        .rdata (dport_rdata)
    );

    sfifo_status u_status (
        .clk        (clk),
        .rst        (rst),
        .rd_stat    (stat_rd),
        .set_lost   (set_lost),
        .set_eos    (scan_end),
        .set_thr    (thr_set),
        .running    (acq_running),
        .full       (full),
        .nfull      (nfull),
        .empty      (empty),
        .irq_en     (fifo_irq_en),
        .stat_rdata (stat_rdata),
        .irq        (fifo_irq)
    );

    // R3: the full flag goes with a non-empty queue
    p_full_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
        full |-> !empty);

endmodule

// File: tb/byte_sample_fifo_tb_top.sv
module byte_sample_fifo_tb_top;

    localparam int FB    = 64;
    localparam int DEPTH = FB / 2;

    localparam logic [15:0] VEC [8] = '{
        16'h0001, 16'hFFFE, 16'h8000, 16'h7FFF,
        16'hA55A, 16'h1234, 16'h00FF, 16'hFF00
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        acq_running = 1'b0;
    logic        scan_end = 1'b0;
    logic        dport_rd = 1'b0;
    logic        dport_wr = 1'b0;
    logic [7:0]  dport_wdata = '0;
    logic [7:0]  dport_rdata;
    logic        stat_rd = 1'b0;
    logic [7:0]  stat_rdata;
    logic        fifo_clear = 1'b0;
    logic        fifo_irq_en = 1'b0;
    logic        fifo_irq;
    logic        near_empty;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    byte_sample_fifo #(.FIFO_BYTES(FB)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .acq_running (acq_running),
        .scan_end    (scan_end),
        .dport_rd    (dport_rd),
        .dport_wr    (dport_wr),
        .dport_wdata (dport_wdata),
        .dport_rdata (dport_rdata),
        .stat_rd     (stat_rd),
        .stat_rdata  (stat_rdata),
        .fifo_clear  (fifo_clear),
        .fifo_irq_en (fifo_irq_en),
        .fifo_irq    (fifo_irq),
        .near_empty  (near_empty)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input logic [15:0] v);
        smp_valid = 1'b1;
        smp_data  = v;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        dport_rd = 1'b1;
        @(negedge clk);
        dport_rd = 1'b0;
        b = dport_rdata;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        dport_wr    = 1'b1;
        dport_wdata = b;
        @(negedge clk);
        dport_wr = 1'b0;
    endtask

    task automatic rd_stat(output logic [7:0] s);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        s = stat_rdata;
    endtask

    task automatic clear_cmd();
        fifo_clear = 1'b1;
        @(negedge clk);
        fifo_clear = 1'b0;
    endtask

    initial begin
        #(5 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] b, s;
        idle(4);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        check("R1 rdata", dport_rdata, 8'h00);
        check("R1 irq", fifo_irq, 0);
        check("R10 near_empty at reset", near_empty, 1);
        rd_stat(s);
        check("R1 status", s, 8'h81);

        // R2: table walk, low byte then high byte in order
        for (int i = 0; i < 8; i++) push(VEC[i]);
        for (int i = 0; i < 8; i++) begin
            rd_byte(b);
            check("R2 low byte", b, VEC[i][7:0]);
            rd_byte(b);
            check("R2 high byte", b, VEC[i][15:8]);
        end

        // R4: empty read repeats, pointers intact
        rd_byte(b);
        check("R4 empty repeat", b, 8'hFF);
        push(16'hC3A5);
        rd_byte(b);
        check("R4 next low", b, 8'hA5);
        rd_byte(b);
        check("R4 next high", b, 8'hC3);
        rd_stat(s);
        check("R1 status idle empty", s, 8'h81);

        // R5: program NE=4, NF=10 free bytes; extra writes ignored
        clear_cmd();
        wr_byte(8'h04); wr_byte(8'h00); wr_byte(8'h0A); wr_byte(8'h00);
        wr_byte(8'hFF); wr_byte(8'hFF);
        for (int i = 0; i < 26; i++) push(16'h0100 + 16'(i));
        idle(2);
        rd_stat(s);
        check("R5 R6 below near-full", s, 8'h80);
        check("R10 near_empty above threshold", near_empty, 0);
        fifo_irq_en = 1'b1;
        idle(1);
        check("R7 no irq before threshold", fifo_irq, 0);
        push(16'h0100 + 16'd26);
        idle(2);
        check("R7 irq on threshold", fifo_irq, 1);
        rd_stat(s);
        check("R6 R7 near-full and event", s, 8'h8A);
        rd_stat(s);
        check("R8 event cleared", s, 8'h82);
        check("R7 irq cleared", fifo_irq, 0);

        // R3: fill to capacity, then one dropped push
        for (int i = 27; i < DEPTH; i++) push(16'h0100 + 16'(i));
        push(16'hDEAD);
        idle(2);
        rd_stat(s);
        check("R3 full and data lost", s, 8'hA6);
        rd_stat(s);
        check("R8 lost cleared", s, 8'h86);
        for (int i = 0; i < DEPTH; i++) begin
            rd_byte(b);
            check("R3 drain low", b, 8'(16'h0100 + 16'(i)));
            rd_byte(b);
            check("R3 drain high", b, 8'h01);
        end
        rd_byte(b);
        check("R3 dropped word absent", b, 8'h01);
        rd_stat(s);
        check("R3 empty after drain", s, 8'h81);
        check("R10 near_empty after drain", near_empty, 1);

        // R9: clear in the middle of a pair
        push(16'h2211);
        push(16'h4433);
        rd_byte(b);
        check("R9 first low", b, 8'h11);
        clear_cmd();
        push(16'h3C4B);
        rd_byte(b);
        check("R9 low after clear", b, 8'h4B);
        rd_byte(b);
        check("R9 high after clear", b, 8'h3C);
        rd_byte(b);
        check("R9 R4 empty after clear", b, 8'h3C);

        // R11, R8: end of scan, running bits, same-cycle read
        acq_running = 1'b1;
        scan_end = 1'b1;
        @(negedge clk);
        scan_end = 1'b0;
        rd_stat(s);
        check("R11 eos latched", s, 8'h51);
        rd_stat(s);
        check("R8 eos cleared", s, 8'h41);
        scan_end = 1'b1;
        stat_rd  = 1'b1;
        @(negedge clk);
        scan_end = 1'b0;
        stat_rd  = 1'b0;
        check("R8 same-cycle read sees old", stat_rdata, 8'h41);
        rd_stat(s);
        check("R8 same-cycle event kept", s, 8'h51);

        // R7: enable low masks the request but not the event
        fifo_irq_en = 1'b0;
        for (int i = 0; i < 27; i++) push(16'h0200 + 16'(i));
        idle(2);
        check("R7 irq masked", fifo_irq, 0);
        rd_stat(s);
        check("R7 event with mask", s, 8'h4A);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule